// File: doc/BRIEF.md
# SPI Ferroelectric RAM Access Sequencer

This block is the host side of an SPI link to a ferroelectric RAM. A caller places one request (read or write, a byte offset and a byte count) on the request port. The block then frames the whole access on the serial pins: chip select low, an opcode byte, the offset as two or three bytes with the most significant byte first, then the data bytes back to back at the full serial clock rate. Ferroelectric memory writes at bus speed, so nothing is polled after a write. The block pulses `done` as chip select rises, and the next request may be taken on the following cycle.

A write is always split into two frames. The first frame carries only the one-byte write-enable command. Chip select then stays high for one full serial clock period, and the second frame carries the write itself. Write bytes are pulled from `wrData` one at a time, and each byte taken is marked by `wrTake`. Read bytes come back on `rdData` with a one-cycle `rdValid` strobe.

The serial clock idles low (mode 0). The half period is `clkDiv + 1` system clock cycles, and `clkDiv` is captured when a request is accepted. An erase request, the reserved operation code, or a configuration that asks for address bits merged into the opcode is refused with an `err` pulse, and the serial pins are not touched.

Top module: `fram_seq`

## Requirements
- R1: While reset is held and after it is released, `csN` is 1, `sclk` is 0, and `busy`, `done`, `err`, `rdValid` and `wrTake` are 0.
- R2: A read (`reqOp` = 2'b00) produces one frame: opcode 0x03, then the offset (2 bytes when `cfgAddr3` = 0, 3 bytes when `cfgAddr3` = 1, MSB first), then `reqLen` further bytes. Each of those bytes is assembled MSB first from `miso` and presented on `rdData` with a one-cycle `rdValid`.
- R3: A write (`reqOp` = 2'b01) produces two frames. The first holds only the single byte 0x06. The second holds 0x02, then the offset as in R2, then `reqLen` bytes taken from `wrData`, with exactly one `wrTake` pulse per data byte.
- R4: Between the two frames of a write, `csN` stays high for at least 2*(`clkDiv`+1) clock cycles.
- R5: Mode 0 framing: `sclk` is low whenever `csN` is high, `mosi` does not change while `sclk` is high, and bits travel MSB first in both directions.
- R6: Within a frame, successive `sclk` edges are exactly `clkDiv`+1 clock cycles apart, with no pause at byte boundaries.
- R7: `done` is high for exactly one cycle per completed request, in the cycle in which `csN` returns high at the end of the last frame.
- R8: A request presented while `busy` is high is ignored and does not alter the transfer in progress.
- R9: An erase (`reqOp` = 2'b10) or reserved (2'b11) request gives an `err` pulse in the cycle after acceptance, and no frame is started.
- R10: A request made while `cfgMergeCmd` is 1 gives an `err` pulse and no frame is started.
- R11: No status wait follows a write. `busy` is low in the cycle of `done`, and a valid request accepted in that cycle drives `csN` low in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when `busy` is low |
| reqOp | input | 2 | 00 read, 01 write, 10 erase (refused), 11 reserved (refused) |
| reqAddr | input | 24 | Byte offset in the memory |
| reqLen | input | LEN_W | Number of data bytes |
| cfgAddr3 | input | 1 | 0: two offset bytes, 1: three offset bytes |
| cfgMergeCmd | input | 1 | 1 requests address bits in the opcode (unsupported) |
| clkDiv | input | DIV_W | Serial half period minus one, in clock cycles |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| err | output | 1 | One-cycle pulse on a refused request |
| wrData | input | 8 | Next write byte |
| wrTake | output | 1 | Pulse: the byte on `wrData` was taken |
| rdData | output | 8 | Last received read byte |
| rdValid | output | 1 | Pulse: `rdData` holds a new byte |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
The properties assume that `reqOp`, `cfgMergeCmd` and `reqValid` are driven to known values during every cycle after reset, and that a request is held for one cycle only, so that acceptance is seen exactly once. The bench changes request fields only away from the rising edge and keeps each strobe for a single cycle. Its memory model changes `miso` only after a falling `sclk` or the falling edge of `csN`, which respects the mode 0 sampling window the sequencer relies on. `wrData` is advanced only after `wrTake`, so the byte the sequencer loads is always the one the bench expects.

// File: rtl/fram_seq_pkg.sv
package fram_seq_pkg;

  localparam int ADDR_W = 24;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seqState_t;

  // Strobes from the control FSM to the serial datapath
  typedef struct packed {
    logic       start;
    logic       load;
    logic [7:0] txByte;
    logic       tickEn;
    logic       shiftEn;
    logic       capture;
  } dpCtl_t;

endpackage

// File: rtl/fram_seq_dp.sv
module fram_seq_dp
  import fram_seq_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             miso,
  output logic             tick,
  output logic             byteDone,
  output logic             sclk,
  output logic             mosi,
  output logic [7:0]       rxByte
);

  localparam int BIT_W = 3;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(7);

  logic [DIV_W-1:0] divLat;
  logic [DIV_W-1:0] divCnt;
  logic             sclkR;
  logic [7:0]       shOut;
  logic [7:0]       shIn;
  logic [BIT_W-1:0] bitCnt;

  assign tick     = ctl.tickEn && (divCnt == divLat);
  assign byteDone = ctl.shiftEn && tick && sclkR && (bitCnt == LAST_BIT);
  assign sclk     = sclkR;
  assign mosi     = shOut[7];

  // Half-period timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLat <= '0;
      divCnt <= '0;
    end else begin
      if (ctl.start) divLat <= clkDiv;
      if (!ctl.tickEn || tick) divCnt <= '0;
      else                     divCnt <= divCnt + 1'b1;
    end
  end

  // Shift engine: rise samples, fall advances
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkR  <= 1'b0;
      shOut  <= '0;
      shIn   <= '0;
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      if (ctl.shiftEn && tick) begin
        if (!sclkR) begin
          sclkR <= 1'b1;
          shIn  <= {shIn[6:0], miso};
        end else begin
          sclkR <= 1'b0;
          if (bitCnt != LAST_BIT) begin
            shOut  <= {shOut[6:0], 1'b0};
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
      if (ctl.load) begin
        shOut  <= ctl.txByte;
        bitCnt <= '0;
      end
      if (ctl.capture) rxByte <= shIn;
    end
  end

endmodule

// File: rtl/fram_seq_ctrl.sv
module fram_seq_ctrl
  import fram_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              cfgAddr3,
  input  logic              cfgMergeCmd,
  input  logic [7:0]        wrData,
  input  logic              tick,
  input  logic              byteDone,
  output dpCtl_t            ctl,
  output logic              csN,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rdValid,
  output logic              wrTake
);

  localparam int IDX_W = LEN_W + 2;

  seqState_t         state;
  logic              isWrite;
  logic              inWren;
  logic              addr3;
  logic              gapHalf;
  logic [ADDR_W-1:0] addrLat;
  logic [LEN_W-1:0]  lenLat;
  logic [IDX_W-1:0]  byteIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [IDX_W-1:0]  nxtIdx;
  logic [IDX_W-1:0]  hdrCur;
  logic [IDX_W-1:0]  hdrReq;
  logic [7:0]        nxtByte;
  logic              accept;
  logic              reqBad;
  logic              lastByte;
  logic              curIsData;
  logic              nxtIsData;

  assign busy      = (state != ST_IDLE);
  assign accept    = reqValid && (state == ST_IDLE);
  assign reqBad    = reqOp[1] || cfgMergeCmd;
  assign hdrCur    = addr3 ? IDX_W'(3) : IDX_W'(2);
  assign hdrReq    = cfgAddr3 ? IDX_W'(3) : IDX_W'(2);
  assign nxtIdx    = byteIdx + 1'b1;
  assign lastByte  = (byteIdx == lastIdx);
  assign curIsData = (byteIdx > hdrCur);
  assign nxtIsData = (nxtIdx > hdrCur);

  // Byte that follows the current one in the frame
  always_comb begin
    if (nxtIdx == IDX_W'(1))
      nxtByte = addr3 ? addrLat[23:16] : addrLat[15:8];
    else if (nxtIdx == IDX_W'(2))
      nxtByte = addr3 ? addrLat[15:8] : addrLat[7:0];
    else if ((nxtIdx == IDX_W'(3)) && addr3)
      nxtByte = addrLat[7:0];
    else
      nxtByte = wrData;
  end

  always_comb begin
    ctl         = '0;
    ctl.tickEn  = (state != ST_IDLE);
    ctl.shiftEn = (state == ST_SHIFT);
    ctl.start   = accept && !reqBad;
    ctl.capture = byteDone && !isWrite && curIsData;
    if (ctl.start) begin
      ctl.load   = 1'b1;
      ctl.txByte = (reqOp == OP_WRITE) ? OPC_WREN : OPC_READ;
    end else if ((state == ST_GAP) && tick && gapHalf) begin
      ctl.load   = 1'b1;
      ctl.txByte = OPC_WRITE;
    end else if (byteDone && !lastByte) begin
      ctl.load   = 1'b1;
      ctl.txByte = nxtByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      csN     <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
      rdValid <= 1'b0;
      wrTake  <= 1'b0;
      isWrite <= 1'b0;
      inWren  <= 1'b0;
      addr3   <= 1'b0;
      gapHalf <= 1'b0;
      addrLat <= '0;
      lenLat  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      rdValid <= ctl.capture;
      wrTake  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reqBad) begin
              err <= 1'b1;
            end else begin
              isWrite <= (reqOp == OP_WRITE);
              inWren  <= (reqOp == OP_WRITE);
              addr3   <= cfgAddr3;
              addrLat <= reqAddr;
              lenLat  <= reqLen;
              byteIdx <= '0;
              lastIdx <= (reqOp == OP_WRITE) ? '0 : hdrReq + IDX_W'(reqLen);
              csN     <= 1'b0;
              state   <= ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (tick) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (byteDone) begin
            if (lastByte) begin
              state <= ST_TAIL;
            end else begin
              byteIdx <= nxtIdx;
              wrTake  <= isWrite && !inWren && nxtIsData;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            csN <= 1'b1;
            if (inWren) begin
              gapHalf <= 1'b0;
              state   <= ST_GAP;
            end else begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (!gapHalf) begin
              gapHalf <= 1'b1;
            end else begin
              csN     <= 1'b0;
              inWren  <= 1'b0;
              byteIdx <= '0;
              lastIdx <= hdrCur + IDX_W'(lenLat);
              state   <= ST_LEAD;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fram_seq.sv
module fram_seq
  import fram_seq_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              cfgAddr3,
  input  logic              cfgMergeCmd,
  input  logic [DIV_W-1:0]  clkDiv,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [7:0]        wrData,
  output logic              wrTake,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);

  dpCtl_t dpCtl;
  logic   tick;
  logic   byteDone;

  fram_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .cfgAddr3   (cfgAddr3),
    .cfgMergeCmd(cfgMergeCmd),
    .wrData     (wrData),
    .tick       (tick),
    .byteDone   (byteDone),
    .ctl        (dpCtl),
    .csN        (csN),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .rdValid    (rdValid),
    .wrTake     (wrTake)
  );

  fram_seq_dp #(.DIV_W(DIV_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .clkDiv  (clkDiv),
    .miso    (miso),
    .tick    (tick),
    .byteDone(byteDone),
    .sclk    (sclk),
    .mosi    (mosi),
    .rxByte  (rdData)
  );

endmodule

// File: rtl/fram_seq_chk.sv
module fram_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqOp,
  input logic       cfgMergeCmd,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       csN,
  input logic       sclk,
  input logic       mosi
);

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R5

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R5

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (csN && !busy)); // R9

  AST_BAD_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && (reqOp[1] || cfgMergeCmd)) |=> (err && csN)); // R10

  AST_START_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !reqOp[1] && !cfgMergeCmd) |=> (!csN && busy)); // R11

endmodule

bind fram_seq fram_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqOp      (reqOp),
  .cfgMergeCmd(cfgMergeCmd),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .csN        (csN),
  .sclk       (sclk),
  .mosi       (mosi)
);

// File: tb/fram_seq_bench.sv
module fram_seq_bench;

  localparam int LEN_W = 16;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [1:0]       reqOp = 2'b00;
  logic [23:0]      reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic             cfgAddr3 = 1'b0;
  logic             cfgMergeCmd = 1'b0;
  logic [DIV_W-1:0] clkDiv = '0;
  logic             busy, done, err, wrTake, rdValid, sclk, csN, mosi;
  logic [7:0]       wrData, rdData;
  logic             misoR = 1'b1;

  always #5 clk = ~clk;

  fram_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_fram_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqLen(reqLen), .cfgAddr3(cfgAddr3),
    .cfgMergeCmd(cfgMergeCmd), .clkDiv(clkDiv), .busy(busy), .done(done),
    .err(err), .wrData(wrData), .wrTake(wrTake), .rdData(rdData),
    .rdValid(rdValid), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(misoR)
  );

  int vecs = 0;
  int fails = 0;

  // Monitor and memory-model state (written only by the monitor)
  logic [7:0] txB [0:31][0:15];
  int         txLen [0:31];
  int         gapAt [0:31];
  int         txCnt = 0;
  logic [7:0] rdBuf [0:63];
  int         rdCnt = 0;
  int         widx = 0;
  int         doneCnt = 0;
  int         doneBad = 0;
  int         errCnt = 0;
  int         perBad = 0;
  int         bits = 0;
  int         byteCnt = 0;
  int         gap = 0;
  int         sinceEdge = 0;
  bit         haveEdge = 0;
  logic [7:0] sh = '0;
  logic       prevCs = 1'b1;
  logic       prevSclk = 1'b0;

  // Stimulus state (written only by tasks)
  logic [7:0] wbuf [0:15];
  int         wBase = 0;
  int         curDiv = 0;

  assign wrData = wbuf[(widx - wBase) & 15];

  function automatic logic [7:0] resp(input int p);
    return 8'((p * 37 + 90) & 255);
  endfunction

  always @(negedge clk) begin
    logic [7:0] r;
    sinceEdge = sinceEdge + 1;
    if (prevCs && !csN) begin
      bits = 0; byteCnt = 0; haveEdge = 0;
      r = resp(0); misoR = r[7];
      if (txCnt < 32) gapAt[txCnt] = gap;
      gap = 0;
    end
    if (!csN && (sclk != prevSclk)) begin
      if (haveEdge && sinceEdge != curDiv + 1) perBad = perBad + 1;
      haveEdge = 1; sinceEdge = 0;
    end
    if (!csN && !prevSclk && sclk) begin
      sh = {sh[6:0], mosi};
      bits = bits + 1;
      if (bits == 8) begin
        if (txCnt < 32 && byteCnt < 16) txB[txCnt][byteCnt] = sh;
        byteCnt = byteCnt + 1; bits = 0;
      end
    end
    if (!csN && prevSclk && !sclk) begin
      r = resp(byteCnt); misoR = r[7 - bits];
    end
    if (!prevCs && csN) begin
      if (txCnt < 32) txLen[txCnt] = byteCnt;
      txCnt = txCnt + 1;
    end
    if (done) begin
      doneCnt = doneCnt + 1;
      if (!(!prevCs && csN)) doneBad = doneBad + 1;
    end
    if (err) errCnt = errCnt + 1;
    if (rdValid) begin
      rdBuf[rdCnt & 63] = rdData;
      rdCnt = rdCnt + 1;
    end
    if (wrTake) widx = widx + 1;
    if (csN) gap = gap + 1;
    prevCs = csN; prevSclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs = vecs + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [23:0] a, input int len,
                       input bit a3, input bit merge, input int div);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqLen = LEN_W'(len);
    cfgAddr3 = a3; cfgMergeCmd = merge; clkDiv = DIV_W'(div);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitEnd();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done || err) break;
    end
  endtask

  function automatic logic [7:0] hdrByte(input logic [23:0] a, input bit a3, input int k);
    if (a3) return (k == 1) ? a[23:16] : (k == 2) ? a[15:8] : a[7:0];
    return (k == 1) ? a[15:8] : a[7:0];
  endfunction

  task automatic t_reset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    chk(csN == 1'b1 && sclk == 1'b0, "R1 pins in reset", {csN, sclk}, 2'b10);
    chk({busy, done, err, rdValid, wrTake} == 5'b0, "R1 status in reset",
        {busy, done, err, rdValid, wrTake}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && !busy && !sclk, "R1 idle after reset", {csN, busy, sclk}, 3'b100);
  endtask

  task automatic t_read(input logic [23:0] a, input int len, input bit a3, input int div);
    int t0 = txCnt, r0 = rdCnt, d0 = doneCnt, db0 = doneBad, p0 = perBad;
    int nA = a3 ? 3 : 2;
    curDiv = div;
    issue(2'b00, a, len, a3, 1'b0, div);
    waitEnd();
    repeat (3) @(negedge clk);
    chk(txCnt - t0 == 1, "R2 one frame", txCnt - t0, 1);
    chk(txLen[t0] == 1 + nA + len, "R2 frame length", txLen[t0], 1 + nA + len);
    chk(txB[t0][0] == 8'h03, "R2 read opcode", txB[t0][0], 8'h03);
    for (int k = 1; k <= nA; k++)
      chk(txB[t0][k] == hdrByte(a, a3, k), "R2 offset byte MSB first",
          txB[t0][k], hdrByte(a, a3, k));
    chk(rdCnt - r0 == len, "R2 read strobes", rdCnt - r0, len);
    for (int i = 0; i < len; i++)
      chk(rdBuf[(r0 + i) & 63] == resp(1 + nA + i), "R5 read byte MSB first",
          rdBuf[(r0 + i) & 63], resp(1 + nA + i));
    chk(perBad == p0, "R6 half period", perBad - p0, 0);
    chk(doneCnt - d0 == 1 && doneBad == db0, "R7 done at release", doneCnt - d0, 1);
  endtask

  task automatic t_write(input logic [23:0] a, input int len, input bit a3, input int div);
    int t0 = txCnt, d0 = doneCnt, p0 = perBad;
    int nA = a3 ? 3 : 2;
    curDiv = div;
    wBase = widx;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'((i * 53 + 17 + div) & 255);
    issue(2'b01, a, len, a3, 1'b0, div);
    waitEnd();
    repeat (3) @(negedge clk);
    chk(txCnt - t0 == 2, "R3 two frames", txCnt - t0, 2);
    chk(txLen[t0] == 1 && txB[t0][0] == 8'h06, "R3 enable frame", txB[t0][0], 8'h06);
    chk(gapAt[t0 + 1] >= 2 * (div + 1), "R4 release gap", gapAt[t0 + 1], 2 * (div + 1));
    chk(txLen[t0 + 1] == 1 + nA + len, "R3 write frame length", txLen[t0 + 1], 1 + nA + len);
    chk(txB[t0 + 1][0] == 8'h02, "R3 write opcode", txB[t0 + 1][0], 8'h02);
    for (int k = 1; k <= nA; k++)
      chk(txB[t0 + 1][k] == hdrByte(a, a3, k), "R3 offset byte",
          txB[t0 + 1][k], hdrByte(a, a3, k));
    for (int i = 0; i < len; i++)
      chk(txB[t0 + 1][1 + nA + i] == wbuf[i], "R5 write byte MSB first",
          txB[t0 + 1][1 + nA + i], wbuf[i]);
    chk(widx - wBase == len, "R3 take pulses", widx - wBase, len);
    chk(perBad == p0, "R6 half period", perBad - p0, 0);
    chk(doneCnt - d0 == 1, "R7 one done per write", doneCnt - d0, 1);
  endtask

  task automatic t_refuse(input logic [1:0] op, input bit merge, input string req);
    int t0 = txCnt, e0 = errCnt;
    issue(op, 24'h00ABCD, 2, 1'b0, merge, 0);
    repeat (40) @(negedge clk);
    chk(errCnt - e0 == 1, req, errCnt - e0, 1);
    chk(txCnt == t0 && csN && !busy, req, txCnt - t0, 0);
  endtask

  task automatic t_busyIgnore();
    int t0 = txCnt, d0 = doneCnt, w0 = widx;
    curDiv = 1;
    issue(2'b00, 24'h001234, 4, 1'b0, 1'b0, 1);
    repeat (20) @(negedge clk);
    issue(2'b01, 24'h00FFFF, 2, 1'b1, 1'b0, 0);
    waitEnd();
    repeat (100) @(negedge clk);
    chk(txCnt - t0 == 1, "R8 no extra frame", txCnt - t0, 1);
    chk(txB[t0][0] == 8'h03 && txB[t0][1] == 8'h12, "R8 frame unchanged", txB[t0][1], 8'h12);
    chk(txLen[t0] == 7 && widx == w0, "R8 length unchanged", txLen[t0], 7);
    chk(doneCnt - d0 == 1, "R8 single done", doneCnt - d0, 1);
  endtask

  task automatic t_noWait();
    int t0 = txCnt;
    curDiv = 0;
    wBase = widx;
    issue(2'b01, 24'h000040, 1, 1'b0, 1'b0, 0);
    waitEnd();
    chk(done && !busy, "R11 idle at done", {done, busy}, 2'b10);
    reqValid = 1'b1; reqOp = 2'b00; reqAddr = 24'h000041; reqLen = LEN_W'(1);
    cfgAddr3 = 1'b0; clkDiv = '0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!csN && busy, "R11 immediate start", {csN, busy}, 2'b01);
    waitEnd();
    repeat (3) @(negedge clk);
    chk(txCnt - t0 == 3 && txB[t0 + 2][0] == 8'h03, "R11 read follows write",
        txCnt - t0, 3);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    #(10 * 190000);
    fails = fails + 1;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) wbuf[i] = '0;
    t_reset();
    t_read(24'h00A55A, 3, 1'b0, 0);
    t_read(24'h01C3E7, 2, 1'b1, 2);
    t_write(24'h003C0F, 4, 1'b0, 1);
    t_write(24'h02F00D, 1, 1'b1, 3);
    t_refuse(2'b10, 1'b0, "R9 erase refused");
    t_refuse(2'b11, 1'b0, "R9 reserved op refused");
    t_refuse(2'b00, 1'b1, "R10 merged address refused");
    t_busyIgnore();
    t_noWait();
    summary();
    $finish;
  end

endmodule